// File: doc/BRIEF.md
# Rotating Register Stack with Occupancy Tags

This block holds a small file of wide data registers that software-visible operations address as a circular stack. A pointer names the current stack top. Every relative slot ST(i) resolves to the physical entry (top + i) modulo the depth. Each entry carries a single occupancy tag. Operations that read an unoccupied entry raise an empty fault. A plain write to an occupied entry raises a full fault. Two operations are exempt from these faults: the examine read and the store from ST(0).

A host issues at most one operation per cycle, using a valid strobe, a 4-bit opcode, a slot index and a data word. All results are registered. Read data, a read strobe and a fault strobe with its kind appear one cycle after the operation is accepted. The pointer, the tag vector and a 16-bit status view of the four condition bits also update at that edge. A faulting operation changes no state.

Top module: `fpr_stack`

## Requirements
- R1: After synchronous reset the pointer reads 0, every tag reads empty, the status word reads 0, and neither strobe is active.
- R2: Push (opcode 1) moves the pointer to (top-1) mod 8, writes the data into that entry and marks it full. If that entry is already full, a full fault (kind 2) is raised instead.
- R3: Pop (opcode 2) returns the entry at the pointer, marks it empty and moves the pointer to (top+1) mod 8. If that entry is empty, an empty fault (kind 1) is raised.
- R4: Read (opcode 3) of ST(i) returns entry (top+i) mod 8, with the read strobe and the full flag set one cycle later.
- R5: Read or modify of an empty slot raises an empty fault (kind 1) and produces no read strobe.
- R6: Write (opcode 5) to an empty slot stores the data and marks the slot full. Write to a full slot raises a full fault (kind 2). Modify (opcode 4) of a full slot returns the old value, stores the new one, and never raises a full fault.
- R7: Examine (opcode 6) returns the data and the tag of any slot and never faults.
- R8: Store (opcode 7) copies ST(0) into ST(i) and marks ST(i) full, even if ST(i) is already full. If ST(0) is empty, an empty fault is raised.
- R9: Load-pointer (opcode 8) takes the pointer from data bits [2:0]. Data bits [31:3] have no effect.
- R10: Set-condition (opcode 9) loads data bits [3:0] as {C3,C2,C1,C0}. The status word carries C3, C2, C1 and C0 at bits 14, 10, 9 and 8, and zeros at every other bit.
- R11: A faulting operation leaves the data, the tags and the pointer unchanged. The fault strobe is high for exactly one cycle per faulting operation. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 4 | Operation selector |
| op_idx | input | 3 | Relative slot index i |
| op_data | input | 64 | Write data, pointer value or condition bits |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_data | output | 64 | Read result |
| rd_full | output | 1 | Tag of the slot that was read |
| fault_strobe | output | 1 | Fault raised by last operation |
| fault_kind | output | 2 | 1 empty, 2 full, 0 none |
| top_ptr | output | 3 | Current stack-top pointer |
| tag_vec | output | 8 | Tag per physical entry, 1 is full |
| status_word | output | 16 | Condition-bit status view |

## Verification
An internal pointer that is off by one shows at the next relative read. Every later ST(i) then returns a neighbour's value, and the pointer port differs one cycle after the push or pop that caused it. A tag stuck in the wrong state turns the next access to that entry into a spurious fault or a missing one, visible on the fault strobe in the cycle after the access. The tag vector also shows the error at once. A faulting operation that still commits state shows on the pointer or tag ports in the cycle after the fault.

// File: rtl/fpr_stack_pkg.sv
package fpr_stack_pkg;

   typedef enum logic [3:0] {
      OP_NOP    = 4'd0,
      OP_PUSH   = 4'd1,
      OP_POP    = 4'd2,
      OP_READ   = 4'd3,
      OP_MODIFY = 4'd4,
      OP_WRITE  = 4'd5,
      OP_EXAM   = 4'd6,
      OP_STORE  = 4'd7,
      OP_LDTOP  = 4'd8,
      OP_SETCC  = 4'd9
   } stk_op_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_EMPTY = 2'd1,
      FLT_FULL  = 2'd2
   } stk_fault_e;

endpackage

// File: rtl/fpr_regfile.sv
module fpr_regfile #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tag_set,
   input  logic              tag_clr,
   input  logic [PTR_W-1:0]  tag_addr,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [DEPTH-1:0]  tags
);

   logic [DATA_W-1:0] ent_q [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_entry
      always_ff @(posedge clk) begin
         if (rst) begin
            ent_q[k] <= '0;
            tags[k]  <= 1'b0;
         end else begin
            if (wr_en && wr_addr == PTR_W'(k))
               ent_q[k] <= wr_data;
            if (tag_set && tag_addr == PTR_W'(k))
               tags[k] <= 1'b1;
            else if (tag_clr && tag_addr == PTR_W'(k))
               tags[k] <= 1'b0;
         end
      end
   end

   assign rd_data = ent_q[rd_addr];

   // R2: a single operation never sets and clears a tag together
   assert_single_tag_update_R2: assert property (@(posedge clk) disable iff (rst)
      !(tag_set && tag_clr));

   // R6: a committed set leaves the addressed tag full
   assert_tag_set_lands_R6: assert property (@(posedge clk) disable iff (rst)
      tag_set |=> tags[$past(tag_addr)]);

endmodule

// File: rtl/fpr_ctrl.sv
module fpr_ctrl
   import fpr_stack_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8,
   parameter int CC_W   = 4,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic [PTR_W-1:0]  op_idx,
   input  logic [DATA_W-1:0] op_data,
   input  logic [DEPTH-1:0]  tags,
   input  logic [DATA_W-1:0] rf_rd_data,
   output logic [PTR_W-1:0]  rf_rd_addr,
   output logic              rf_wr_en,
   output logic [PTR_W-1:0]  rf_wr_addr,
   output logic [DATA_W-1:0] rf_wr_data,
   output logic              rf_tag_set,
   output logic              rf_tag_clr,
   output logic [PTR_W-1:0]  rf_tag_addr,
   output logic              rd_hit,
   output logic              rd_tag,
   output stk_fault_e        fault,
   output logic              cc_we,
   output logic [CC_W-1:0]   cc_d,
   output logic [PTR_W-1:0]  top_q
);

   stk_op_e          op;
   logic [PTR_W-1:0] slot, push_slot, top_d;

   assign op        = stk_op_e'(op_code);
   assign slot      = top_q + op_idx;
   assign push_slot = top_q - PTR_W'(1);
   assign cc_d      = op_data[CC_W-1:0];
   assign rf_rd_addr = (op == OP_POP || op == OP_STORE) ? top_q : slot;
   assign rd_tag     = tags[rf_rd_addr];

   always_comb begin
      rf_wr_en    = 1'b0;
      rf_wr_addr  = slot;
      rf_wr_data  = op_data;
      rf_tag_set  = 1'b0;
      rf_tag_clr  = 1'b0;
      rf_tag_addr = slot;
      rd_hit      = 1'b0;
      fault       = FLT_NONE;
      cc_we       = 1'b0;
      top_d       = top_q;
      if (op_valid) begin
         unique case (op)
            OP_PUSH: begin
               if (tags[push_slot]) fault = FLT_FULL;
               else begin
                  rf_wr_en    = 1'b1;
                  rf_wr_addr  = push_slot;
                  rf_tag_set  = 1'b1;
                  rf_tag_addr = push_slot;
                  top_d       = push_slot;
               end
            end
            OP_POP: begin
               if (!tags[top_q]) fault = FLT_EMPTY;
               else begin
                  rd_hit      = 1'b1;
                  rf_tag_clr  = 1'b1;
                  rf_tag_addr = top_q;
                  top_d       = top_q + PTR_W'(1);
               end
            end
            OP_READ: begin
               if (!tags[slot]) fault = FLT_EMPTY;
               else rd_hit = 1'b1;
            end
            OP_MODIFY: begin
               if (!tags[slot]) fault = FLT_EMPTY;
               else begin
                  rd_hit   = 1'b1;
                  rf_wr_en = 1'b1;
               end
            end
            OP_WRITE: begin
               if (tags[slot]) fault = FLT_FULL;
               else begin
                  rf_wr_en   = 1'b1;
                  rf_tag_set = 1'b1;
               end
            end
            OP_EXAM:  rd_hit = 1'b1;
            OP_STORE: begin
               if (!tags[top_q]) fault = FLT_EMPTY;
               else begin
                  rf_wr_en   = 1'b1;
                  rf_wr_data = rf_rd_data;
                  rf_tag_set = 1'b1;
               end
            end
            OP_LDTOP: top_d = op_data[PTR_W-1:0];
            OP_SETCC: cc_we = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) top_q <= '0;
      else     top_q <= top_d;
   end

   // R11: a fault leaves the pointer where it was
   assert_fault_keeps_top_R11: assert property (@(posedge clk) disable iff (rst)
      (fault != FLT_NONE) |=> $stable(top_q));

   // R11: a fault commits no register write
   assert_fault_no_write_R11: assert property (@(posedge clk) disable iff (rst)
      (fault != FLT_NONE) |-> !(rf_wr_en || rf_tag_set || rf_tag_clr));

   // R2: a successful push steps the pointer down by one
   assert_push_moves_top_R2: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op == OP_PUSH && fault == FLT_NONE)
      |=> (top_q == $past(top_q) - PTR_W'(1)));

   // R3: a successful pop steps the pointer up by one
   assert_pop_moves_top_R3: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op == OP_POP && fault == FLT_NONE)
      |=> (top_q == $past(top_q) + PTR_W'(1)));

   // R7: examine never faults
   assert_exam_no_fault_R7: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op == OP_EXAM) |-> (fault == FLT_NONE));

endmodule

// File: rtl/fpr_status.sv
module fpr_status #(
   parameter int CC_W   = 4,
   parameter int SW_W   = 16,
   parameter int C3_POS = 14,
   parameter int C0_POS = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cc_we,
   input  logic [CC_W-1:0] cc_d,
   output logic [SW_W-1:0] status_word
);

   logic [CC_W-1:0] cc_q;

   always_ff @(posedge clk) begin
      if (rst)        cc_q <= '0;
      else if (cc_we) cc_q <= cc_d;
   end

   // low condition bits sit contiguously from C0_POS, top bit at C3_POS
   for (genvar b = 0; b < SW_W; b++) begin : g_sw
      if (b >= C0_POS && b < C0_POS + CC_W - 1) begin : g_low
         assign status_word[b] = cc_q[b - C0_POS];
      end else if (b == C3_POS) begin : g_high
         assign status_word[b] = cc_q[CC_W-1];
      end else begin : g_zero
         assign status_word[b] = 1'b0;
      end
   end

   // R10: loaded condition bits appear in the status word one cycle later
   assert_cc_load_R10: assert property (@(posedge clk) disable iff (rst)
      cc_we |=> (status_word[C3_POS] == $past(cc_d[CC_W-1]) &&
                 status_word[C0_POS] == $past(cc_d[0])));

   // R10: without a load the status word holds
   assert_cc_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !cc_we |=> $stable(status_word));

endmodule

// File: rtl/fpr_stack.sv
module fpr_stack
   import fpr_stack_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8,
   parameter int CC_W   = 4,
   parameter int SW_W   = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic [PTR_W-1:0]  op_idx,
   input  logic [DATA_W-1:0] op_data,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_full,
   output logic              fault_strobe,
   output logic [1:0]        fault_kind,
   output logic [PTR_W-1:0]  top_ptr,
   output logic [DEPTH-1:0]  tag_vec,
   output logic [SW_W-1:0]   status_word
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < CC_W || DATA_W < PTR_W) begin : g_bad_width
      $error("DATA_W too narrow for pointer or condition operands");
   end
   if (CC_W != 4 || SW_W < 15) begin : g_bad_sw
      $error("status layout needs four condition bits and a 15-bit word");
   end

   logic              rf_wr_en, rf_tag_set, rf_tag_clr, rd_hit, rd_tag, cc_we;
   logic [PTR_W-1:0]  rf_wr_addr, rf_tag_addr, rf_rd_addr;
   logic [DATA_W-1:0] rf_wr_data, rf_rd_data;
   logic [CC_W-1:0]   cc_d;
   stk_fault_e        fault;

   fpr_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
      .clk(clk), .rst(rst),
      .wr_en(rf_wr_en), .wr_addr(rf_wr_addr), .wr_data(rf_wr_data),
      .tag_set(rf_tag_set), .tag_clr(rf_tag_clr), .tag_addr(rf_tag_addr),
      .rd_addr(rf_rd_addr), .rd_data(rf_rd_data), .tags(tag_vec)
   );

   fpr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CC_W(CC_W)) u_ctrl (
      .clk(clk), .rst(rst),
      .op_valid(op_valid), .op_code(op_code), .op_idx(op_idx), .op_data(op_data),
      .tags(tag_vec), .rf_rd_data(rf_rd_data), .rf_rd_addr(rf_rd_addr),
      .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
      .rf_tag_set(rf_tag_set), .rf_tag_clr(rf_tag_clr), .rf_tag_addr(rf_tag_addr),
      .rd_hit(rd_hit), .rd_tag(rd_tag), .fault(fault),
      .cc_we(cc_we), .cc_d(cc_d), .top_q(top_ptr)
   );

   fpr_status #(.CC_W(CC_W), .SW_W(SW_W), .C3_POS(14), .C0_POS(8)) u_sts (
      .clk(clk), .rst(rst), .cc_we(cc_we), .cc_d(cc_d), .status_word(status_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid     <= 1'b0;
         rd_data      <= '0;
         rd_full      <= 1'b0;
         fault_strobe <= 1'b0;
         fault_kind   <= FLT_NONE;
      end else begin
         rd_valid     <= rd_hit;
         fault_strobe <= (fault != FLT_NONE);
         fault_kind   <= fault;
         if (rd_hit) begin
            rd_data <= rf_rd_data;
            rd_full <= rd_tag;
         end
      end
   end

   // R5: a read result and a fault are never reported together
   assert_rd_or_fault_R5: assert property (@(posedge clk) disable iff (rst)
      !(rd_valid && fault_strobe));

   // R11: the strobe and its kind agree
   assert_strobe_kind_R11: assert property (@(posedge clk) disable iff (rst)
      fault_strobe == (fault_kind != 2'd0));

   // R11: with no operation the strobe drops the next cycle
   assert_strobe_one_cycle_R11: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> !fault_strobe);

endmodule

// File: tb/fpr_stack_bench.sv
module fpr_stack_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic [2:0]  op_idx = '0;
   logic [63:0] op_data = '0;
   logic        rd_valid, rd_full, fault_strobe;
   logic [63:0] rd_data;
   logic [1:0]  fault_kind;
   logic [2:0]  top_ptr;
   logic [7:0]  tag_vec;
   logic [15:0] status_word;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   logic [63:0] m_f [8];
   logic [7:0]  m_t;
   logic [2:0]  m_top;
   logic [3:0]  m_cc;

   always #10 clk = ~clk;

   fpr_stack u_fpr_stack (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
      .op_idx(op_idx), .op_data(op_data), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_full(rd_full), .fault_strobe(fault_strobe), .fault_kind(fault_kind),
      .top_ptr(top_ptr), .tag_vec(tag_vec), .status_word(status_word)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] sw_of(input logic [3:0] cc);
      return {1'b0, cc[3], 3'b000, cc[2], cc[1], cc[0], 8'h00};
   endfunction

   task automatic chk_state(input string req);
      chk(req, "top", 64'(top_ptr), 64'(m_top));
      chk(req, "tags", 64'(tag_vec), 64'(m_t));
      chk(req, "status", 64'(status_word), 64'(sw_of(m_cc)));
   endtask

   task automatic run_op(input logic [3:0] op, input logic [2:0] idx,
                         input logic [63:0] d, input string req);
      logic [2:0]  slot, pslot;
      logic [1:0]  e_flt;
      logic        e_rv, e_full;
      logic [63:0] e_rd;
      slot  = m_top + idx;
      pslot = m_top - 3'd1;
      e_flt = 2'd0; e_rv = 1'b0; e_full = 1'b1; e_rd = '0;
      case (op)
         4'd1: if (m_t[pslot]) e_flt = 2'd2;
               else begin m_top = pslot; m_f[pslot] = d; m_t[pslot] = 1'b1; end
         4'd2: if (!m_t[m_top]) e_flt = 2'd1;
               else begin e_rv = 1'b1; e_rd = m_f[m_top]; m_t[m_top] = 1'b0; m_top = m_top + 3'd1; end
         4'd3: if (!m_t[slot]) e_flt = 2'd1;
               else begin e_rv = 1'b1; e_rd = m_f[slot]; end
         4'd4: if (!m_t[slot]) e_flt = 2'd1;
               else begin e_rv = 1'b1; e_rd = m_f[slot]; m_f[slot] = d; end
         4'd5: if (m_t[slot]) e_flt = 2'd2;
               else begin m_f[slot] = d; m_t[slot] = 1'b1; end
         4'd6: begin e_rv = 1'b1; e_rd = m_f[slot]; e_full = m_t[slot]; end
         4'd7: if (!m_t[m_top]) e_flt = 2'd1;
               else begin m_f[slot] = m_f[m_top]; m_t[slot] = 1'b1; end
         4'd8: m_top = d[2:0];
         4'd9: m_cc = d[3:0];
         default: ;
      endcase
      op_valid = 1'b1; op_code = op; op_idx = idx; op_data = d;
      @(negedge clk);
      op_valid = 1'b0;
      chk(req, "fault_kind", 64'(fault_kind), 64'(e_flt));
      chk(req, "fault_strobe", 64'(fault_strobe), 64'(e_flt != 2'd0));
      chk(req, "rd_valid", 64'(rd_valid), 64'(e_rv));
      if (e_rv) begin
         chk(req, "rd_data", rd_data, e_rd);
         chk(req, "rd_full", 64'(rd_full), 64'(e_full));
      end
      chk_state(req);
   endtask

   task automatic idle_chk(input string req);
      @(negedge clk);
      chk(req, "strobe drop", 64'(fault_strobe), 64'd0);
      chk(req, "rd_valid drop", 64'(rd_valid), 64'd0);
      chk_state(req);
   endtask

   function automatic logic [63:0] pat(input int n);
      return 64'h0123_4567_89AB_CDEF * 64'(n + 1) ^ 64'(n);
   endfunction

   initial begin
      for (int k = 0; k < 8; k++) m_f[k] = '0;
      m_t = '0; m_top = '0; m_cc = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk("R1", "fault", 64'(fault_strobe), 64'd0);
      chk("R1", "rd_valid", 64'(rd_valid), 64'd0);
      chk_state("R1");
      run_op(4'd0, 3'd0, 64'hFFFF, "R11");        // R11: no-op
      // R2: fill the stack, then overflow
      for (int n = 0; n < 8; n++) run_op(4'd1, 3'd0, pat(n), "R2");
      run_op(4'd1, 3'd0, pat(99), "R2");
      idle_chk("R11");
      // R4 / R9: every pointer with garbage high bits, every slot
      for (int t = 0; t < 8; t++) begin
         run_op(4'd8, 3'd0, {56'hFEED_FACE_0BAD_F0, 5'b11011, 3'(t)}, "R9");
         for (int i = 0; i < 8; i++) run_op(4'd3, 3'(i), '0, "R4");
      end
      run_op(4'd8, 3'd0, 64'hFFFF_FFF8, "R9");
      // R6: modify full slot, write full slot
      run_op(4'd4, 3'd3, 64'hCAFE_0000_0000_0003, "R6");
      run_op(4'd3, 3'd3, '0, "R6");
      run_op(4'd5, 3'd2, 64'h1234, "R6");
      idle_chk("R11");
      // R3: pop three
      for (int n = 0; n < 3; n++) run_op(4'd2, 3'd0, '0, "R3");
      // R5: read and modify empty slots
      run_op(4'd3, 3'd7, '0, "R5");
      run_op(4'd4, 3'd6, 64'hBAD, "R5");
      run_op(4'd3, 3'd6, '0, "R5");
      // R7: examine empty and full slots
      run_op(4'd6, 3'd7, '0, "R7");
      run_op(4'd6, 3'd0, '0, "R7");
      // R6: write empty slot; R8: store into empty and full slots
      run_op(4'd5, 3'd5, 64'h5555_AAAA_5555_AAAA, "R6");
      run_op(4'd7, 3'd6, '0, "R8");
      run_op(4'd7, 3'd5, '0, "R8");
      run_op(4'd6, 3'd5, '0, "R8");
      // R3 / R5: pop through empties
      for (int n = 0; n < 9; n++) run_op(4'd2, 3'd0, '0, "R3");
      run_op(4'd8, 3'd0, 64'd4, "R9");
      run_op(4'd7, 3'd1, '0, "R8");
      // R10: every condition value
      for (int c = 0; c < 16; c++) run_op(4'd9, 3'd0, {60'hABCDE, 4'(c)}, "R10");
      // R2 / R3: push-pop wrap from every pointer
      for (int t = 0; t < 8; t++) begin
         run_op(4'd8, 3'd0, 64'(t), "R9");
         run_op(4'd1, 3'd0, pat(t + 20), "R2");
         run_op(4'd6, 3'd0, '0, "R7");
         run_op(4'd2, 3'd0, '0, "R3");
         run_op(4'd2, 3'd7, '0, "R5");
      end
      idle_chk("R11");
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule